// File: doc/BRIEF.md
# Receive Interrupt Coalescer with Tag Handshake

This block sits beside a receive DMA engine and decides when the host is interrupted about newly stored messages. Each time a message has landed in host memory the engine pulses `rx_msg_done`. The coalescer counts those pulses and interrupts either when the batch reaches a programmed size or when the oldest pending message has waited a programmed number of 100 µs ticks. A transmit link-consumed pulse also requests an interrupt by itself, so the host can recycle a transmit page without waiting for receive traffic.

When it fires, the block publishes a 32-bit status word with a one-cycle strobe; the DMA engine copies that word to the head of the receive area. The word carries a 4-bit tag, the batch count and a link flag. Several channels can share one interrupt line, so a handler compares the tag with the one it expects to decide whether the interrupt belongs to its channel. After firing, the block is blocked. It stays blocked until software writes back the expected next tag, which is the current tag plus one modulo 16. Messages that arrive while it is blocked are not lost. They accumulate for the following batch.

After reset the block starts blocked with tag 0, so software arms it with an initial acknowledge of tag 1. A DMA hold input keeps the engine idle during DMA reconfiguration.

Top module: `rxc_coalesce`

## Requirements
- R1: After reset, `status_valid` and `irq` are 0, `status_word` is 0, the current tag is 0 and the block is blocked; nothing fires until an acknowledge carrying tag 1 is written.
- R2: The status word holds the tag in bits 3:0, the batch message count in bits 10:4 and the link flag in bit 16, and every other bit is 0.
- R3: While armed, the block fires once the pending message count is non-zero and greater than or equal to `batch_limit`; `status_valid` rises on the clock edge after the count reaches the limit.
- R4: While armed with at least one message pending, an age counter advances on each `tick`, and the block fires once that counter reaches `age_limit`. The counter is cleared when the block fires and does not run while the block is blocked or nothing is pending.
- R5: Firing sets an interrupt request that stays set until an acknowledge whose `ack_tag` equals the current tag plus one modulo 16 is written. That acknowledge clears the request, advances the tag and re-arms the block, and the request reads 0 on the edge after the acknowledge.
- R6: An acknowledge with any other tag value, or one written while the block is armed, has no effect.
- R7: `irq` equals the interrupt request gated by `irq_enable`. Firing and the status word do not depend on `irq_enable`.
- R8: While `dma_hold` is 1, nothing fires, and the pending count, the age counter and the link flag are cleared; messages and link pulses are discarded.
- R9: A `tx_link_done` pulse sets a link flag that, on its own, makes an armed block fire and is reported in bit 16. A pulse that arrives in the firing cycle belongs to the next batch.
- R10: Messages arriving while the block is blocked, or in the firing cycle itself, count toward the next batch; the count saturates at 127.
- R11: `status_valid` is a single-cycle strobe, and `status_word` holds its value between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_msg_done | input | 1 | One message stored in host memory |
| tx_link_done | input | 1 | Transmit link record consumed |
| batch_limit | input | 7 | Message count that triggers an interrupt |
| age_limit | input | AGE_W (8) | Wait limit in tick units |
| irq_enable | input | 1 | Interrupt line enable |
| dma_hold | input | 1 | Holds the engine idle and clears pending state |
| ack_wr | input | 1 | Acknowledge write strobe |
| ack_tag | input | 4 | Tag written with the acknowledge |
| tick | input | 1 | 100 µs time base pulse |
| status_word | output | 32 | Status word for the head of the receive area |
| status_valid | output | 1 | One-cycle strobe when a new status word is published |
| irq | output | 1 | Interrupt line |

## Verification
The riskiest coincidence is a new message or link pulse arriving on the same edge on which a batch fires. The reported batch must exclude the newcomer, and the newcomer must survive as the first member of the next batch. The bench provokes this by holding `rx_msg_done` high for one cycle past the batch limit, and by placing a link pulse exactly on the firing edge. It then checks that the first word reports only the earlier messages and that the next word, released by the acknowledge, carries the leftover message or the link flag. A behavioural model also compares the strobe, the interrupt line and every published word on every clock.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
  localparam int TAG_W = 4;
  localparam int CNT_W = 7;

  typedef struct packed {
    logic [14:0]      rsv_hi;
    logic             link;
    logic [4:0]       rsv_lo;
    logic [CNT_W-1:0] count;
    logic [TAG_W-1:0] tag;
  } rxc_status_t;

  function automatic rxc_status_t rxc_pack(input logic link,
                                           input logic [CNT_W-1:0] count,
                                           input logic [TAG_W-1:0] tag);
    rxc_status_t s;
    s.rsv_hi = '0;
    s.link   = link;
    s.rsv_lo = '0;
    s.count  = count;
    s.tag    = tag;
    return s;
  endfunction
endpackage

// File: rtl/rxc_pend_cnt.sv
module rxc_pend_cnt #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         take,
  input  logic         bump,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] SAT = '1;

  logic [W-1:0] base;
  logic [W-1:0] count_n;

  always_comb begin
    base    = take ? '0 : count;
    count_n = base;
    if (flush)
      count_n = '0;
    else if (bump && (base != SAT))
      count_n = base + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_n;
  end
endmodule

// File: rtl/rxc_age_timer.sv
module rxc_age_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         expired
);
  localparam logic [W-1:0] SAT = '1;

  logic [W-1:0] age;
  logic [W-1:0] age_n;
  logic         adv_en;

  assign adv_en  = run && tick && (age != SAT);
  assign expired = (age >= limit);

  always_comb begin
    age_n = age;
    if (clr)         age_n = '0;
    else if (adv_en) age_n = age + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else        age <= age_n;
  end
endmodule

// File: rtl/rxc_tag_ctl.sv
module rxc_tag_ctl #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic          ack_wr,
  input  logic [TW-1:0] ack_tag,
  output logic          blocked,
  output logic [TW-1:0] tag,
  output logic          irq_req
);
  logic [TW-1:0] tag_inc;
  logic          ack_ok;
  logic          blocked_n;
  logic [TW-1:0] tag_n;
  logic          irq_req_n;

  assign tag_inc = tag + 1'b1;
  assign ack_ok  = blocked && ack_wr && (ack_tag == tag_inc);

  always_comb begin
    blocked_n = blocked;
    tag_n     = tag;
    irq_req_n = irq_req;
    if (fire) begin
      blocked_n = 1'b1;
      irq_req_n = 1'b1;
    end else if (ack_ok) begin
      blocked_n = 1'b0;
      irq_req_n = 1'b0;
      tag_n     = tag_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blocked <= 1'b1;
      tag     <= '0;
      irq_req <= 1'b0;
    end else begin
      blocked <= blocked_n;
      tag     <= tag_n;
      irq_req <= irq_req_n;
    end
  end
endmodule

// File: rtl/rxc_coalesce.sv
module rxc_coalesce
  import rxc_pkg::*;
#(
  parameter int AGE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_msg_done,
  input  logic             tx_link_done,
  input  logic [CNT_W-1:0] batch_limit,
  input  logic [AGE_W-1:0] age_limit,
  input  logic             irq_enable,
  input  logic             dma_hold,
  input  logic             ack_wr,
  input  logic [TAG_W-1:0] ack_tag,
  input  logic             tick,
  output logic [31:0]      status_word,
  output logic             status_valid,
  output logic             irq
);
  logic [CNT_W-1:0] pend;
  logic             aged;
  logic             blocked;
  logic [TAG_W-1:0] tag;
  logic             irq_req;
  logic             link_q;
  logic             link_n;
  logic             fire;
  logic             has_pend;
  rxc_status_t      word_q;
  rxc_status_t      word_n;

  assign has_pend = (pend != '0);
  assign fire = !blocked && !dma_hold &&
                (link_q || (has_pend && ((pend >= batch_limit) || aged)));

  rxc_pend_cnt #(.W(CNT_W)) u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (dma_hold),
    .take  (fire),
    .bump  (rx_msg_done),
    .count (pend)
  );

  rxc_age_timer #(.W(AGE_W)) u_age (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (fire || dma_hold),
    .run     (!blocked && has_pend),
    .tick    (tick),
    .limit   (age_limit),
    .expired (aged)
  );

  rxc_tag_ctl #(.TW(TAG_W)) u_tag (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (fire),
    .ack_wr  (ack_wr),
    .ack_tag (ack_tag),
    .blocked (blocked),
    .tag     (tag),
    .irq_req (irq_req)
  );

  always_comb begin
    if (dma_hold) link_n = 1'b0;
    else          link_n = (link_q && !fire) || tx_link_done;
    word_n = fire ? rxc_pack(link_q, pend, tag) : word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_q       <= 1'b0;
      word_q       <= '0;
      status_valid <= 1'b0;
    end else begin
      link_q       <= link_n;
      word_q       <= word_n;
      status_valid <= fire;
    end
  end

  assign status_word = word_q;
  assign irq         = irq_req && irq_enable;
endmodule

// File: rtl/rxc_coalesce_chk.sv
module rxc_coalesce_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        irq_enable,
  input logic        dma_hold,
  input logic        ack_wr,
  input logic [31:0] status_word,
  input logic        status_valid,
  input logic        irq
);
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    status_valid |=> !status_valid); // R11

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[31:17] == 15'd0) && (status_word[15:11] == 5'd0)); // R2

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_enable |-> !irq); // R7

  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    dma_hold |=> !status_valid); // R8

  AST_FIRE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (status_valid && irq_enable) |-> irq); // R5

  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack_wr) |=> (irq || !irq_enable)); // R5

  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !status_valid |=> (status_valid || $stable(status_word))); // R11
endmodule

bind rxc_coalesce rxc_coalesce_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .irq_enable   (irq_enable),
  .dma_hold     (dma_hold),
  .ack_wr       (ack_wr),
  .status_word  (status_word),
  .status_valid (status_valid),
  .irq          (irq)
);

// File: tb/test_rxc_coalesce.sv
module test_rxc_coalesce;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;

  logic        clk;
  logic        rst_n;
  logic        rx_msg_done;
  logic        tx_link_done;
  logic [6:0]  batch_limit;
  logic [7:0]  age_limit;
  logic        irq_enable;
  logic        dma_hold;
  logic        ack_wr;
  logic [3:0]  ack_tag;
  logic        tick;
  logic [31:0] status_word;
  logic        status_valid;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int n_vld  = 0;
  logic [31:0] last_word = '0;
  bit done = 0;

  rxc_coalesce i_rxc_coalesce (
    .clk(clk), .rst_n(rst_n), .rx_msg_done(rx_msg_done), .tx_link_done(tx_link_done),
    .batch_limit(batch_limit), .age_limit(age_limit), .irq_enable(irq_enable),
    .dma_hold(dma_hold), .ack_wr(ack_wr), .ack_tag(ack_tag), .tick(tick),
    .status_word(status_word), .status_valid(status_valid), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // tick generator, driven away from the active edge
  int tdiv = 0;
  always @(negedge clk) begin
    #1;
    tdiv = (tdiv + 1) % TICK_DIV;
    tick = (tdiv == 0);
  end

  // behavioural reference model
  bit          m_blk;
  int          m_tag, m_pend, m_age;
  bit          m_link, m_irqp, m_vld;
  logic [31:0] m_word;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_blk = 1; m_tag = 0; m_pend = 0; m_age = 0;
      m_link = 0; m_irqp = 0; m_vld = 0; m_word = '0;
    end else begin
      bit f, ok;
      int np, na;
      f  = !m_blk && !dma_hold &&
           (m_link || (m_pend != 0 && (m_pend >= int'(batch_limit) || m_age >= int'(age_limit))));
      ok = m_blk && ack_wr && (int'(ack_tag) == (m_tag + 1) % 16);
      if (f) m_word = (32'(m_link) << 16) | (32'(m_pend) << 4) | 32'(m_tag);
      m_vld = f;
      if (dma_hold) begin
        np = 0; na = 0; m_link = 0;
      end else begin
        np = f ? 0 : m_pend;
        if (rx_msg_done && np < 127) np = np + 1;
        na = m_age;
        if (f) na = 0;
        else if (!m_blk && m_pend != 0 && tick && m_age < 255) na = m_age + 1;
        m_link = (m_link && !f) || tx_link_done;
      end
      m_pend = np; m_age = na;
      if (f) begin m_blk = 1; m_irqp = 1; end
      else if (ok) begin m_blk = 0; m_irqp = 0; m_tag = (m_tag + 1) % 16; end
    end
  end

  // per-cycle comparison and strobe monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (status_valid !== m_vld) begin
        errors++; $display("FAIL R11 model: status_valid=%0b expected %0b", status_valid, m_vld);
      end
      checks++;
      if (irq !== (m_irqp && irq_enable)) begin
        errors++; $display("FAIL R5 model: irq=%0b expected %0b", irq, m_irqp && irq_enable);
      end
      if (m_vld) begin
        checks++;
        if (status_word !== m_word) begin
          errors++; $display("FAIL R2 model: word=%h expected %h", status_word, m_word);
        end
      end
      if (status_valid) begin n_vld++; last_word = status_word; end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic cyc();
    @(negedge clk); #2;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++; $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic msgs(input int n);
    rx_msg_done = 1'b1;
    repeat (n) cyc();
    rx_msg_done = 1'b0;
  endtask

  task automatic link_pulse();
    tx_link_done = 1'b1; cyc(); tx_link_done = 1'b0;
  endtask

  task automatic ack(input int t);
    ack_wr = 1'b1; ack_tag = 4'(t); cyc(); ack_wr = 1'b0;
  endtask

  task automatic wait_vld(input int base, input int maxc, input string req, output int took);
    took = 0;
    while (n_vld == base && took < maxc) begin cyc(); took++; end
    chk(req, 32'(n_vld - base), 32'd1);
  endtask

  task automatic quiet(input int n, input string req);
    int base;
    base = n_vld;
    repeat (n) cyc();
    chk(req, 32'(n_vld - base), 32'd0);
  endtask

  initial begin
    int b, took;
    rst_n = 0; rx_msg_done = 0; tx_link_done = 0; batch_limit = 7'd16; age_limit = 8'd10;
    irq_enable = 1; dma_hold = 0; ack_wr = 0; ack_tag = 0; tick = 0;
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    // R1 reset state
    chk("R1 valid", 32'(status_valid), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 word", status_word, 0);
    msgs(3);
    quiet(60, "R1 blocked before first ack");
    ack(1);
    b = n_vld;
    wait_vld(b, 200, "R4 age fire", took);
    chk("R4 age delay not early", 32'(took >= 30), 1);
    chk("R4 word", last_word, 32'h31);
    chk("R5 irq raised", 32'(irq), 1);
    cyc();
    chk("R11 strobe low", 32'(status_valid), 0);
    chk("R11 word held", status_word, 32'h31);
    // R6 wrong acknowledge
    ack(5);
    repeat (4) cyc();
    chk("R6 irq stays", 32'(irq), 1);
    ack(2);
    chk("R5 irq cleared", 32'(irq), 0);
    // R3 count limit
    b = n_vld;
    msgs(16);
    wait_vld(b, 10, "R3 count fire", took);
    chk("R3 word", last_word, 32'h102);
    // R10 saturation while blocked, R7 gating
    msgs(130);
    irq_enable = 0;
    b = n_vld;
    ack(3);
    wait_vld(b, 10, "R10 saturated batch", took);
    chk("R10 word", last_word, 32'h7F3);
    chk("R7 irq masked", 32'(irq), 0);
    irq_enable = 1;
    cyc();
    chk("R7 irq unmasked", 32'(irq), 1);
    // R9 link alone
    ack(4);
    b = n_vld;
    link_pulse();
    wait_vld(b, 10, "R9 link fire", took);
    chk("R9 word", last_word, 32'h10004);
    // R8 hold
    dma_hold = 1;
    ack(5);
    msgs(20);
    link_pulse();
    quiet(60, "R8 quiet in hold");
    dma_hold = 0;
    quiet(80, "R8 pending cleared");
    b = n_vld;
    msgs(1);
    wait_vld(b, 200, "R8 resumes", took);
    chk("R8 word", last_word, 32'h15);
    // R10 message on the firing edge
    ack(6);
    b = n_vld;
    msgs(17);
    chk("R10 one fire", 32'(n_vld - b), 1);
    chk("R10 firing batch", last_word, 32'h106);
    b = n_vld;
    ack(7);
    wait_vld(b, 200, "R10 leftover", took);
    chk("R10 leftover word", last_word, 32'h17);
    // R9 link on the firing edge
    ack(8);
    b = n_vld;
    msgs(16);
    link_pulse();
    cyc();
    chk("R9 batch without link", last_word, 32'h108);
    b = n_vld;
    ack(9);
    wait_vld(b, 10, "R9 link next batch", took);
    chk("R9 link word", last_word, 32'h10009);
    repeat (5) cyc();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule